// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a two-port memory array and watches the two access ports, called left and right. When both ports are enabled and present the same address, it decides which of them must back off. In master mode it drives an active-low busy line to the losing port and suppresses that port's writes inside the block. The write strobe is dropped, so the port is not stalled and its data is discarded. In slave mode the block makes no decision of its own. Each port's busy line then arrives as an input from another arbiter and gates that port's writes directly.

Everything runs on a single clock. Each edge records every port's enable and address. A port whose enable has just gone low, or whose address has just changed, counts as a fresh arrival in that cycle. When a collision starts, the fresh arrival loses. If both ports are fresh, or neither is, the right port loses. The loser is held for as long as the collision lasts and is released on the edge at which it ends. An option for a half-depth array drops the top address bit from the comparison.

Top module: `dpram_collision_arbiter`

## Requirements
- R1: When either enable is high or the compared addresses differ at a clock edge, both busy outputs are high and neither write inhibit is set in the following cycle.
- R2: When a collision starts at an edge and only one port is a fresh arrival (enable newly low or address changed since the previous edge), that port's busy output goes low after that edge. The other port keeps busy high.
- R3: When a collision starts with both ports fresh, or with neither fresh, the right port gets busy low and the left keeps busy high. The two busy outputs are never low together.
- R4: While the collision continues, the chosen loser stays the loser, even if both ports move together to a new common address.
- R5: Busy is released (driven high) in the cycle after the edge at which the collision ends, whether an enable went high or the addresses diverged.
- R6: In master mode the losing port's write inhibit is high and its write-go output is low, whatever its write strobe. The winning port's write passes: write-go = enable low AND strobe low AND NOT inhibit.
- R7: With master_mode low, both busy outputs are high. Each port's write inhibit then follows its busy input (low means inhibit) in the same cycle. In master mode the busy inputs have no effect.
- R8: With HALF_DEPTH set, address bit ADDR_W-1 is ignored. Addresses differing only in that bit collide.
- R9: While rst is high, both busy outputs are high and no loser is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_mode | input | 1 | 1: decide collisions; 0: take busy from inputs |
| l_ce_n | input | 1 | Left port enable, active low |
| l_we_n | input | 1 | Left port write strobe, active low |
| l_addr | input | ADDR_W | Left port address |
| r_ce_n | input | 1 | Right port enable, active low |
| r_we_n | input | 1 | Right port write strobe, active low |
| r_addr | input | ADDR_W | Right port address |
| l_busy_in_n | input | 1 | Left busy from another arbiter (slave mode) |
| r_busy_in_n | input | 1 | Right busy from another arbiter (slave mode) |
| l_busy_out_n | output | 1 | Left busy, active low (master mode) |
| r_busy_out_n | output | 1 | Right busy, active low (master mode) |
| l_wr_inhibit | output | 1 | Left writes suppressed |
| r_wr_inhibit | output | 1 | Right writes suppressed |
| l_wr_go | output | 1 | Left write allowed to reach the array |
| r_wr_go | output | 1 | Right write allowed to reach the array |

## Verification
The properties assume that the port inputs change only between clock edges. They also assume that master_mode is a quasi-static select, and that the busy inputs matter only in slave mode. The bench drives every input a short delay after the rising edge and holds it across the next edge. It changes master_mode only while the ports sit in a known state. Collisions are made with fresh and stable arrivals, with exact ties, and with joint address moves, so that each branch of the loser choice is reached from a released state.

// File: rtl/dpca_pkg.sv
package dpca_pkg;

    localparam int NUM_PORTS = 2;
    localparam int PORT_L    = 0;
    localparam int PORT_R    = 1;

    typedef enum logic [1:0] {
        LOSER_NONE  = 2'd0,
        LOSER_LEFT  = 2'd1,
        LOSER_RIGHT = 2'd2
    } loser_e;

    typedef struct packed {
        logic active;   // enable low this cycle
        logic fresh;    // active and newly arrived since last edge
    } port_stat_t;

    // Loser of a newly detected collision: the sole fresh port loses,
    // every other combination hands the loss to the right port.
    function automatic loser_e pick_loser(input logic l_fresh, input logic r_fresh);
        if (l_fresh && !r_fresh) begin
            return LOSER_LEFT;
        end
        return LOSER_RIGHT;
    endfunction

    function automatic logic is_loser(input loser_e who, input int port);
        if (port == PORT_L) begin
            return who == LOSER_LEFT;
        end
        return who == LOSER_RIGHT;
    endfunction

endpackage

// File: rtl/dpca_port_track.sv
module dpca_port_track
    import dpca_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int CMP_W  = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [CMP_W-1:0]  addr_cmp,
    output port_stat_t        stat
);

    logic             prev_active;
    logic [CMP_W-1:0] prev_addr;

    assign addr_cmp = addr[CMP_W-1:0];

    generate
        if (CMP_W < ADDR_W) begin : g_drop_msb
            logic unused_msb;
            assign unused_msb = ^addr[ADDR_W-1:CMP_W];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_active <= 1'b0;
            prev_addr   <= '0;
        end else begin
            prev_active <= !ce_n;
            prev_addr   <= addr_cmp;
        end
    end

    always_comb begin
        stat.active = !ce_n;
        stat.fresh  = !ce_n && (!prev_active || (prev_addr != addr_cmp));
    end

    // R2: a port that stays enabled on an unchanged address is never fresh
    p_stable_not_fresh_r2: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !$past(rst) && !$past(ce_n) && (addr_cmp == $past(addr_cmp))) |-> !stat.fresh);

endmodule

// File: rtl/dpca_judge.sv
module dpca_judge
    import dpca_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       master_mode,
    input  logic       match,
    input  port_stat_t l_stat,
    input  port_stat_t r_stat,
    output loser_e     loser
);

    loser_e loser_nxt;

    always_comb begin
        if (!master_mode || !match) begin
            loser_nxt = LOSER_NONE;
        end else if (loser != LOSER_NONE) begin
            loser_nxt = loser;
        end else begin
            loser_nxt = pick_loser(l_stat.fresh, r_stat.fresh);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            loser <= LOSER_NONE;
        end else begin
            loser <= loser_nxt;
        end
    end

    // R1 / R5: no collision at an edge means nobody is held afterwards
    p_release_r5: assert property (@(posedge clk) disable iff (rst)
        !match |=> (loser == LOSER_NONE));

    // R4: an ongoing collision keeps its loser
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (master_mode && match && loser != LOSER_NONE) |=> $stable(loser));

    // R2: sole fresh left port loses a new collision
    p_left_late_r2: assert property (@(posedge clk) disable iff (rst)
        (master_mode && match && loser == LOSER_NONE && l_stat.fresh && !r_stat.fresh)
        |=> (loser == LOSER_LEFT));

    // R3: ties and stable-stable starts go against the right port
    p_tie_right_r3: assert property (@(posedge clk) disable iff (rst)
        (master_mode && match && loser == LOSER_NONE && (l_stat.fresh == r_stat.fresh))
        |=> (loser == LOSER_RIGHT));

endmodule

// File: rtl/dpca_wr_gate.sv
module dpca_wr_gate (
    input  logic clk,
    input  logic rst,
    input  logic master_mode,
    input  logic lost,
    input  logic ce_n,
    input  logic we_n,
    input  logic busy_in_n,
    output logic busy_out_n,
    output logic wr_inhibit,
    output logic wr_go
);

    always_comb begin
        busy_out_n = !(master_mode && lost);
        wr_inhibit = master_mode ? lost : !busy_in_n;
        wr_go      = !ce_n && !we_n && !wr_inhibit;
    end

    // R6: a port that has lost arbitration never writes
    p_loser_blocked_r6: assert property (@(posedge clk) disable iff (rst)
        (master_mode && lost) |-> !wr_go);

    // R7: slave mode keeps the busy output released
    p_slave_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !master_mode |-> busy_out_n);

    // R7: slave mode obeys an asserted busy input
    p_slave_obeys_r7: assert property (@(posedge clk) disable iff (rst)
        (!master_mode && !busy_in_n) |-> !wr_go);

endmodule

// File: rtl/dpram_collision_arbiter.sv
module dpram_collision_arbiter
    import dpca_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter bit HALF_DEPTH = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              master_mode,
    input  logic              l_ce_n,
    input  logic              l_we_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_ce_n,
    input  logic              r_we_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              l_busy_in_n,
    input  logic              r_busy_in_n,
    output logic              l_busy_out_n,
    output logic              r_busy_out_n,
    output logic              l_wr_inhibit,
    output logic              r_wr_inhibit,
    output logic              l_wr_go,
    output logic              r_wr_go
);

    localparam int CMP_W = HALF_DEPTH ? ADDR_W - 1 : ADDR_W;

    logic [NUM_PORTS-1:0] ce_n_v;
    logic [NUM_PORTS-1:0] we_n_v;
    logic [NUM_PORTS-1:0] busy_in_v;
    logic [NUM_PORTS-1:0] busy_out_v;
    logic [NUM_PORTS-1:0] inhibit_v;
    logic [NUM_PORTS-1:0] go_v;
    logic [ADDR_W-1:0]    addr_v [NUM_PORTS];
    logic [CMP_W-1:0]     cmp_v  [NUM_PORTS];
    port_stat_t           stat_v [NUM_PORTS];
    logic                 match;
    loser_e               loser;

    assign ce_n_v    = {r_ce_n, l_ce_n};
    assign we_n_v    = {r_we_n, l_we_n};
    assign busy_in_v = {r_busy_in_n, l_busy_in_n};
    assign addr_v[PORT_L] = l_addr;
    assign addr_v[PORT_R] = r_addr;

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            dpca_port_track #(
                .ADDR_W (ADDR_W),
                .CMP_W  (CMP_W)
            ) i_track (
                .clk      (clk),
                .rst      (rst),
                .ce_n     (ce_n_v[p]),
                .addr     (addr_v[p]),
                .addr_cmp (cmp_v[p]),
                .stat     (stat_v[p])
            );

            dpca_wr_gate i_gate (
                .clk         (clk),
                .rst         (rst),
                .master_mode (master_mode),
                .lost        (is_loser(loser, p)),
                .ce_n        (ce_n_v[p]),
                .we_n        (we_n_v[p]),
                .busy_in_n   (busy_in_v[p]),
                .busy_out_n  (busy_out_v[p]),
                .wr_inhibit  (inhibit_v[p]),
                .wr_go       (go_v[p])
            );
        end
    endgenerate

    assign match = stat_v[PORT_L].active && stat_v[PORT_R].active
                   && (cmp_v[PORT_L] == cmp_v[PORT_R]);

    dpca_judge i_judge (
        .clk         (clk),
        .rst         (rst),
        .master_mode (master_mode),
        .match       (match),
        .l_stat      (stat_v[PORT_L]),
        .r_stat      (stat_v[PORT_R]),
        .loser       (loser)
    );

    assign l_busy_out_n = busy_out_v[PORT_L];
    assign r_busy_out_n = busy_out_v[PORT_R];
    assign l_wr_inhibit = inhibit_v[PORT_L];
    assign r_wr_inhibit = inhibit_v[PORT_R];
    assign l_wr_go      = go_v[PORT_L];
    assign r_wr_go      = go_v[PORT_R];

    // R3: both busy outputs are never low together
    p_one_loser_r3: assert property (@(posedge clk) disable iff (rst)
        !(!l_busy_out_n && !r_busy_out_n));

    // R9: the cycle after a reset edge shows no busy
    p_reset_idle_r9: assert property (@(posedge clk)
        rst |=> (l_busy_out_n && r_busy_out_n));

endmodule

// File: tb/test_dpram_collision_arbiter.sv
module test_dpram_collision_arbiter;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 13;
    localparam int NVEC       = 12;

    typedef struct packed {
        logic          l_ce_n;
        logic          l_we_n;
        logic [AW-1:0] l_addr;
        logic          r_ce_n;
        logic          r_we_n;
        logic [AW-1:0] r_addr;
        logic [3:0]    exp;    // {l_busy_n, r_busy_n, l_go, r_go}
    } vec_t;

    // Master mode walk; each row is applied, one edge passes, then outputs are checked.
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b1, 13'h000, 1'b1, 1'b1, 13'h000, 4'b1100}, // idle R1
        '{1'b0, 1'b0, 13'h010, 1'b1, 1'b1, 13'h000, 4'b1110}, // left alone R1
        '{1'b0, 1'b0, 13'h010, 1'b0, 1'b0, 13'h010, 4'b1010}, // right late R2
        '{1'b0, 1'b0, 13'h010, 1'b0, 1'b0, 13'h010, 4'b1010}, // hold R4
        '{1'b0, 1'b0, 13'h010, 1'b0, 1'b0, 13'h011, 4'b1111}, // diverge R5
        '{1'b0, 1'b0, 13'h011, 1'b0, 1'b0, 13'h011, 4'b0101}, // left late R2
        '{1'b0, 1'b1, 13'h011, 1'b0, 1'b0, 13'h011, 4'b0101}, // hold R4
        '{1'b1, 1'b1, 13'h011, 1'b0, 1'b0, 13'h011, 4'b1101}, // enable off R5
        '{1'b1, 1'b1, 13'h000, 1'b1, 1'b1, 13'h000, 4'b1100}, // idle R1
        '{1'b0, 1'b0, 13'h1AB, 1'b0, 1'b0, 13'h1AB, 4'b1010}, // tie R3
        '{1'b0, 1'b0, 13'h0C0, 1'b0, 1'b0, 13'h0C0, 4'b1010}, // joint move R4
        '{1'b0, 1'b0, 13'h0C0, 1'b1, 1'b1, 13'h0C0, 4'b1110}  // right off R5
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          master_mode;
    logic          l_ce_n, l_we_n, r_ce_n, r_we_n;
    logic [AW-1:0] l_addr, r_addr;
    logic          l_busy_in_n, r_busy_in_n;
    logic          l_busy_out_n, r_busy_out_n, l_wr_inhibit, r_wr_inhibit, l_wr_go, r_wr_go;
    logic          h_l_busy_out_n, h_r_busy_out_n, h_l_wr_inhibit, h_r_wr_inhibit, h_l_wr_go, h_r_wr_go;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpram_collision_arbiter #(.ADDR_W(AW), .HALF_DEPTH(1'b0)) i_dpram_collision_arbiter (
        .clk(clk), .rst(rst), .master_mode(master_mode),
        .l_ce_n(l_ce_n), .l_we_n(l_we_n), .l_addr(l_addr),
        .r_ce_n(r_ce_n), .r_we_n(r_we_n), .r_addr(r_addr),
        .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
        .l_busy_out_n(l_busy_out_n), .r_busy_out_n(r_busy_out_n),
        .l_wr_inhibit(l_wr_inhibit), .r_wr_inhibit(r_wr_inhibit),
        .l_wr_go(l_wr_go), .r_wr_go(r_wr_go)
    );

    dpram_collision_arbiter #(.ADDR_W(AW), .HALF_DEPTH(1'b1)) i_dpram_collision_arbiter_half (
        .clk(clk), .rst(rst), .master_mode(master_mode),
        .l_ce_n(l_ce_n), .l_we_n(l_we_n), .l_addr(l_addr),
        .r_ce_n(r_ce_n), .r_we_n(r_we_n), .r_addr(r_addr),
        .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
        .l_busy_out_n(h_l_busy_out_n), .r_busy_out_n(h_r_busy_out_n),
        .l_wr_inhibit(h_l_wr_inhibit), .r_wr_inhibit(h_r_wr_inhibit),
        .l_wr_go(h_l_wr_go), .r_wr_go(h_r_wr_go)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic lc, input logic lw, input logic [AW-1:0] la,
                         input logic rc, input logic rw, input logic [AW-1:0] ra);
        l_ce_n = lc; l_we_n = lw; l_addr = la;
        r_ce_n = rc; r_we_n = rw; r_addr = ra;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst         = 1'b1;
        master_mode = 1'b1;
        l_busy_in_n = 1'b1;
        r_busy_in_n = 1'b1;
        // R9: a collision presented during reset raises no busy
        drive(1'b0, 1'b0, 13'h005, 1'b0, 1'b0, 13'h005);
        tick();
        tick();
        chk("R9", "l_busy_out_n in reset", l_busy_out_n, 1'b1);
        chk("R9", "r_busy_out_n in reset", r_busy_out_n, 1'b1);
        chk("R9", "r_wr_inhibit in reset", r_wr_inhibit, 1'b0);
        drive(1'b1, 1'b1, 13'h000, 1'b1, 1'b1, 13'h000);
        tick();
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            drive(VECS[i].l_ce_n, VECS[i].l_we_n, VECS[i].l_addr,
                  VECS[i].r_ce_n, VECS[i].r_we_n, VECS[i].r_addr);
            tick();
            chk("R1-walk", $sformatf("v%0d l_busy_out_n", i), l_busy_out_n, VECS[i].exp[3]);
            chk("R2-walk", $sformatf("v%0d r_busy_out_n", i), r_busy_out_n, VECS[i].exp[2]);
            chk("R6", $sformatf("v%0d l_wr_go", i), l_wr_go, VECS[i].exp[1]);
            chk("R6", $sformatf("v%0d r_wr_go", i), r_wr_go, VECS[i].exp[0]);
        end

        // R8: addresses differing only in the top bit collide in half depth only
        drive(1'b0, 1'b0, 13'h1005, 1'b0, 1'b0, 13'h0005);
        tick();
        chk("R8", "full r_busy_out_n", r_busy_out_n, 1'b1);
        chk("R8", "half r_busy_out_n", h_r_busy_out_n, 1'b0);
        chk("R8", "half l_busy_out_n", h_l_busy_out_n, 1'b1);
        chk("R8", "half r_wr_inhibit", h_r_wr_inhibit, 1'b1);
        chk("R8", "half l_wr_go", h_l_wr_go, 1'b1);
        drive(1'b1, 1'b1, 13'h000, 1'b1, 1'b1, 13'h000);
        tick();

        // R7: slave mode, busy inputs gate writes directly
        master_mode = 1'b0;
        l_busy_in_n = 1'b0;
        r_busy_in_n = 1'b1;
        drive(1'b0, 1'b0, 13'h020, 1'b0, 1'b0, 13'h020);
        #1;
        chk("R7", "slave l_wr_inhibit", l_wr_inhibit, 1'b1);
        chk("R7", "slave l_wr_go", l_wr_go, 1'b0);
        chk("R7", "slave r_wr_go", r_wr_go, 1'b1);
        tick();
        chk("R7", "slave l_busy_out_n", l_busy_out_n, 1'b1);
        chk("R7", "slave r_busy_out_n", r_busy_out_n, 1'b1);

        // R3: master again with both ports stable on one address, right loses;
        // R7: the asserted left busy input is ignored in master mode
        #1 master_mode = 1'b1;
        tick();
        chk("R3", "stable start l_busy_out_n", l_busy_out_n, 1'b1);
        chk("R3", "stable start r_busy_out_n", r_busy_out_n, 1'b0);
        chk("R7", "master ignores l_busy_in_n", l_wr_go, 1'b1);
        chk("R6", "loser r_wr_inhibit", r_wr_inhibit, 1'b1);

        finish_run();
    end

endmodule